// File: doc/BRIEF.md
# Drive Level Adjust Calculator

During link training the sink reports, for each lane, the transmit voltage swing and pre-emphasis it would like the source to use. This block takes the two request bytes that carry these wishes for four lanes and works out one common drive setting for the next training round. Only the lanes in use are considered. The common setting is the worst case over those lanes, limited to what the source transmitter can deliver.

The swing and the pre-emphasis level are each the largest value that any active lane asks for. The swing is then capped at the source's top level. The pre-emphasis is capped at a limit that depends on the capped swing. Whenever a cap is reached, a flag is raised in the result. The resulting training byte is registered and placed on all four lane outputs. A one-cycle done pulse follows the start strobe. Sending the bytes to the sink is left to the surrounding logic.

Top module: `drive_adj_calc`

## Requirements
- R1: After reset, all four lane outputs are 8'h00 and `done` is 0.
- R2: Lanes 0 and 1 are decoded from `adj_lo`, and lanes 2 and 3 from `adj_hi`. In each byte the even lane's swing is bits [1:0] and its pre-emphasis is bits [3:2]. The odd lane's swing is bits [5:4] and its pre-emphasis is bits [7:6].
- R3: Lane i is active when `lane_cnt` > i, and values above 4 count as 4. The chosen swing and the chosen pre-emphasis are each the maximum over the active lanes only. Requests from inactive lanes have no effect. With no active lane, both are 0.
- R4: In the output byte the swing sits in bits [1:0]. When the chosen swing is 3, the output swing is 3 and the swing-limit flag (bit 2) is 1. Otherwise the flag is 0.
- R5: The pre-emphasis limit is taken from the output swing: 2 for swing 0 or 1, 1 for swing 2, and 0 for swing 3.
- R6: The output pre-emphasis sits in bits [4:3]. When the chosen pre-emphasis is at or above the limit, the field equals the limit and the pre-emphasis-limit flag (bit 5) is 1. Otherwise the field is the chosen value and the flag is 0. Bits [7:6] are always 0.
- R7: All four lane outputs carry the same byte, whatever `lane_cnt` is.
- R8: The result is captured on the clock edge where `start` is 1. `done` is 1 for exactly the following cycle. The outputs hold their value while `start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Compute strobe |
| adj_lo | input | 8 | Adjust request byte for lanes 0 and 1 |
| adj_hi | input | 8 | Adjust request byte for lanes 2 and 3 |
| lane_cnt | input | 3 | Number of active lanes |
| lane_set_0 | output | 8 | Training byte for lane 0 |
| lane_set_1 | output | 8 | Training byte for lane 1 |
| lane_set_2 | output | 8 | Training byte for lane 2 |
| lane_set_3 | output | 8 | Training byte for lane 3 |
| done | output | 1 | One-cycle pulse after start |

## Verification
The assertions assume that the request bytes and `lane_cnt` are stable on the edge where `start` is sampled. They place no limit on the spacing of start strobes. The stimulus changes the inputs only away from the clock edge and drops `start` after a single cycle. It then waits an idle cycle before the next request, so that the hold and single-pulse properties are exercised between strobes. `lane_cnt` values 0, 3 and above 4 are driven as well as 1, 2 and 4, so the active-lane rule is tested beyond the usual lane counts.

// File: rtl/drive_adj_pkg.sv
package drive_adj_pkg;

    localparam int NUM_LANES  = 4;
    localparam int LEVEL_W    = 2;
    localparam int CNT_W      = 3;
    localparam int BYTE_W     = 8;

    typedef logic [LEVEL_W-1:0] level_t;

    // one lane's request pair
    typedef struct packed {
        level_t swing;
        level_t preemph;
    } lane_req_t;

    // training byte layout, MSB first
    typedef struct packed {
        logic [1:0] rsvd;
        logic       pe_max;
        level_t     pe;
        logic       sw_max;
        level_t     sw;
    } train_byte_t;

    localparam level_t SWING_CEIL = 2'd3;

    // pre-emphasis limit allowed at a given (already capped) swing
    function automatic level_t pe_ceiling(input level_t sw);
        case (sw)
            2'd0, 2'd1: pe_ceiling = 2'd2;
            2'd2:       pe_ceiling = 2'd1;
            default:    pe_ceiling = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dla_lane_decode.sv
module dla_lane_decode
    import drive_adj_pkg::*;
#(
    parameter bit ODD_LANE = 1'b0
) (
    input  logic [BYTE_W-1:0] req_byte,
    output lane_req_t         req
);
    localparam int BASE = ODD_LANE ? 4 : 0;

    assign req.swing   = req_byte[BASE +: LEVEL_W];
    assign req.preemph = req_byte[BASE+2 +: LEVEL_W];
endmodule

// File: rtl/dla_max_reduce.sv
module dla_max_reduce
    import drive_adj_pkg::*;
#(
    parameter int LANES = NUM_LANES
) (
    input  lane_req_t [LANES-1:0] reqs,
    input  logic      [LANES-1:0] active,
    output lane_req_t             worst
);
    always_comb begin
        worst = '0;
        for (int i = 0; i < LANES; i++) begin
            if (active[i]) begin
                if (reqs[i].swing > worst.swing)
                    worst.swing = reqs[i].swing;
                if (reqs[i].preemph > worst.preemph)
                    worst.preemph = reqs[i].preemph;
            end
        end
    end
endmodule

// File: rtl/dla_limit.sv
module dla_limit
    import drive_adj_pkg::*;
(
    input  lane_req_t   worst,
    output train_byte_t tbyte
);
    level_t sw_capped;
    level_t pe_lim;
    logic   sw_hit;
    logic   pe_hit;

    always_comb begin
        sw_hit    = (worst.swing >= SWING_CEIL);
        sw_capped = sw_hit ? SWING_CEIL : worst.swing;
        pe_lim    = pe_ceiling(sw_capped);
        pe_hit    = (worst.preemph >= pe_lim);

        tbyte        = '0;
        tbyte.sw     = sw_capped;
        tbyte.sw_max = sw_hit;
        tbyte.pe     = pe_hit ? pe_lim : worst.preemph;
        tbyte.pe_max = pe_hit;
    end
endmodule

// File: rtl/drive_adj_calc.sv
module drive_adj_calc
    import drive_adj_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       adj_lo,
    input  logic [7:0]       adj_hi,
    input  logic [2:0]       lane_cnt,
    output logic [7:0]       lane_set_0,
    output logic [7:0]       lane_set_1,
    output logic [7:0]       lane_set_2,
    output logic [7:0]       lane_set_3,
    output logic             done
);
    localparam int BYTES = NUM_LANES / 2;

    logic [BYTES-1:0][BYTE_W-1:0] req_bytes;
    lane_req_t [NUM_LANES-1:0]    lane_reqs;
    logic      [NUM_LANES-1:0]    lane_act;
    lane_req_t                    worst;
    train_byte_t                  next_byte;
    train_byte_t                  set_q;
    logic                         done_q;

    assign req_bytes[0] = adj_lo;
    assign req_bytes[1] = adj_hi;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        dla_lane_decode #(
            .ODD_LANE (1'(i % 2))
        ) u_dec (
            .req_byte (req_bytes[i/2]),
            .req      (lane_reqs[i])
        );
        assign lane_act[i] = (32'(lane_cnt) > i);
    end

    dla_max_reduce #(
        .LANES (NUM_LANES)
    ) u_max (
        .reqs   (lane_reqs),
        .active (lane_act),
        .worst  (worst)
    );

    dla_limit u_lim (
        .worst (worst),
        .tbyte (next_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start)
                set_q <= next_byte;
        end
    end

    assign lane_set_0 = set_q;
    assign lane_set_1 = set_q;
    assign lane_set_2 = set_q;
    assign lane_set_3 = set_q;
    assign done       = done_q;
endmodule

// File: rtl/dla_checker.sv
module dla_checker
    import drive_adj_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [7:0] adj_lo,
    input logic [7:0] adj_hi,
    input logic [2:0] lane_cnt,
    input logic [7:0] lane_set_0,
    input logic [7:0] lane_set_1,
    input logic [7:0] lane_set_2,
    input logic [7:0] lane_set_3,
    input logic       done
);
    logic unused_in;
    assign unused_in = ^{adj_lo, adj_hi, lane_cnt};

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R8
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(lane_set_0)); // R8
    AST_LANES_MATCH: assert property (@(posedge clk) disable iff (rst)
        (lane_set_0 == lane_set_1) && (lane_set_0 == lane_set_2)
        && (lane_set_0 == lane_set_3)); // R7
    AST_SW_FLAG: assert property (@(posedge clk) disable iff (rst)
        lane_set_0[2] == (lane_set_0[1:0] == 2'd3)); // R4
    AST_PE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        lane_set_0[4:3] <= pe_ceiling(lane_set_0[1:0])); // R5
    AST_PE_FLAG: assert property (@(posedge clk) disable iff (rst)
        lane_set_0[5] |-> (lane_set_0[4:3] == pe_ceiling(lane_set_0[1:0]))); // R6
    AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        lane_set_0[7:6] == 2'b00); // R6
endmodule

bind drive_adj_calc dla_checker u_chk (.*);

// File: tb/drive_adj_calc_tb.sv
module drive_adj_calc_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [7:0] adj_lo, adj_hi;
    logic [2:0] lane_cnt;
    logic [7:0] ls0, ls1, ls2, ls3;
    logic       done;
    int         n_run = 0;
    int         n_fail = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    drive_adj_calc u_dut (
        .clk (clk), .rst (rst), .start (start),
        .adj_lo (adj_lo), .adj_hi (adj_hi), .lane_cnt (lane_cnt),
        .lane_set_0 (ls0), .lane_set_1 (ls1), .lane_set_2 (ls2), .lane_set_3 (ls3),
        .done (done)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // expected training byte from the requirements
    function automatic logic [7:0] model(input logic [7:0] lo, input logic [7:0] hi,
                                         input logic [2:0] cnt);
        int n = (cnt > 4) ? 4 : int'(cnt);
        int sw = 0, pe = 0, lim;
        logic [7:0] r;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = (i < 2) ? lo : hi;
            int sh = (i % 2) * 4;
            int s = int'((b >> sh) & 8'h3);
            int p = int'((b >> (sh + 2)) & 8'h3);
            if (s > sw) sw = s;
            if (p > pe) pe = p;
        end
        r = 8'h00;
        if (sw >= 3) begin sw = 3; r[2] = 1'b1; end
        lim = (sw <= 1) ? 2 : (sw == 2) ? 1 : 0;
        if (pe >= lim) begin pe = lim; r[5] = 1'b1; end
        r[1:0] = 2'(sw);
        r[4:3] = 2'(pe);
        return r;
    endfunction

    // one request; checks the byte, all four lanes, the pulse and the hold
    task automatic run_req(input string req, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [2:0] cnt);
        logic [7:0] exp = model(lo, hi, cnt);
        @(negedge clk);
        adj_lo = lo; adj_hi = hi; lane_cnt = cnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req, ls0, exp);
        check({req, " R7 lane1"}, ls1, exp);
        check({req, " R7 lane2"}, ls2, exp);
        check({req, " R7 lane3"}, ls3, exp);
        check({req, " R8 done high"}, {7'd0, done}, 8'h01);
        adj_lo = ~lo; adj_hi = ~hi;
        @(negedge clk);
        check({req, " R8 done low"}, {7'd0, done}, 8'h00);
        check({req, " R8 hold"}, ls0, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; adj_lo = 8'hFF; adj_hi = 8'hFF; lane_cnt = 3'd4;
        repeat (3) @(negedge clk);
        check("R1 lane0", ls0, 8'h00);
        check("R1 lane3", ls3, 8'h00);
        check("R1 done", {7'd0, done}, 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_decode();
        run_req("R2 lane0 sw1 pe1", 8'h05, 8'h00, 3'd1);      // expect 09
        check("R2 lane0 value", ls0, 8'h09);
        run_req("R2 lane1 sw2 pe0", 8'h20, 8'h00, 3'd2);      // expect 02
        check("R2 lane1 value", ls0, 8'h02);
        run_req("R2 lane2 pe1", 8'h00, 8'h04, 3'd4);
        run_req("R2 lane3 sw1", 8'h00, 8'h10, 3'd4);
        check("R2 lane3 value", ls0, 8'h01);
    endtask

    task automatic t_max();
        run_req("R3 max mixed", 8'h16, 8'h41, 3'd4);
        run_req("R3 max lane order", 8'h41, 8'h16, 3'd4);
        run_req("R3 three lanes", 8'h00, 8'h21, 3'd3);
    endtask

    task automatic t_inactive();
        run_req("R3 inactive ignored", 8'h00, 8'hFF, 3'd2);
        check("R3 inactive value", ls0, 8'h00);
        run_req("R3 zero lanes", 8'hFF, 8'hFF, 3'd0);
        check("R3 zero lanes value", ls0, 8'h00);
        run_req("R3 cnt above 4", 8'h00, 8'h20, 3'd7);
        check("R3 cnt7 value", ls0, 8'h02);
        run_req("R7 one lane all outputs", 8'h01, 8'hFF, 3'd1);
    endtask

    task automatic t_swing();
        run_req("R4 swing 3 flag", 8'h03, 8'h00, 3'd1);
        check("R4 swing3 value", ls0, 8'h27);
        run_req("R4 swing 2 no flag", 8'h02, 8'h00, 3'd1);
        check("R4 swing2 value", ls0, 8'h02);
    endtask

    task automatic t_preemph();
        run_req("R5 sw0 pe1", 8'h04, 8'h00, 3'd1);
        check("R5 sw0 pe1 value", ls0, 8'h08);
        run_req("R6 sw0 pe3", 8'h0C, 8'h00, 3'd1);
        check("R6 sw0 pe3 value", ls0, 8'h30);
        run_req("R5 sw1 pe2", 8'h09, 8'h00, 3'd1);
        run_req("R5 sw2 pe0", 8'h02, 8'h00, 3'd1);
        run_req("R6 sw2 pe1", 8'h06, 8'h00, 3'd1);
        check("R6 sw2 pe1 value", ls0, 8'h2A);
        run_req("R6 sw3 pe3", 8'h0F, 8'h00, 3'd1);
        check("R6 sw3 pe3 value", ls0, 8'h27);
        run_req("R5 capped swing from lanes", 8'h43, 8'h00, 3'd2);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_max();
        t_inactive();
        t_swing();
        t_preemph();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule